// File: doc/BRIEF.md
# Fast Interrupt Priority Override Unit

This block sits next to an interrupt priority arbiter and lets software promote up to two chosen interrupt sources to fast handling. Each of the two fast channels has a match register naming one IRQ number and a split 21-bit handler address held in a low and a high vector register. When a matched source is pending at priority level 2 it beats every other level-2 request, whatever its index. The block then reports it with the fast flag set and the programmed handler address in place of a table vector.

Each cycle the block takes a pending-IRQ vector and a 2-bit priority level per IRQ. It registers the winning request, the fast flag and the vector address to fetch. When no fast channel wins, a plain fallback picks the lowest-numbered pending IRQ at the highest active level, and its vector is the IRQ number times two. Registers are reached over a 16-bit bus with an address, a write strobe, write data and combinational read data.

Top module: `fast_irq_override`

## Requirements
- R1: After reset all six registers read 0, and req_valid_o, req_fast_o, req_irq_o and req_vec_o are 0.
- R2: Register offsets: 0xB channel 0 match, 0xC channel 0 low vector, 0xD channel 0 high vector, 0xE channel 1 match, 0xF channel 1 low vector, 0x10 channel 1 high vector. A write is visible on read data in the next cycle. Any other offset reads 0.
- R3: In the match registers, bits 15..7 read 0 and ignore writes. In the high vector registers, bits 15..5 read 0 and ignore writes.
- R4: The priority level of IRQ k is irq_lvl_i[2k+1:2k]. Level 0 means the IRQ does not take part, and levels 1 to 3 rank low to high. The fallback winner is the lowest-index pending IRQ at the highest active level, with req_fast_o = 0 and req_vec_o = 2 × IRQ.
- R5: A fast channel hits when its matched IRQ is pending at level 2 and no level-3 request is pending. The matched IRQ then wins over every other level-2 request. The outputs are req_fast_o = 1 and req_vec_o = {high[4:0], low[15:0]} of that channel.
- R6: A matched IRQ at level 1 or 3 arbitrates through the fallback, with req_fast_o = 0.
- R7: When both channels hit with different IRQs, channel 0 wins.
- R8: When both match registers name the same IRQ, channel 0's vector address is output.
- R9: A pending level-3 request wins over any fast channel.
- R10: All outputs are registered. A change on the inputs appears on the outputs after exactly one rising clock edge.
- R11: With no eligible pending IRQ, req_valid_o = 0 and req_irq_o, req_fast_o and req_vec_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 5 | Register offset |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data (combinational) |
| irq_pend_i | input | N_IRQ | Pending request per IRQ |
| irq_lvl_i | input | 2*N_IRQ | 2-bit priority level per IRQ |
| req_valid_o | output | 1 | A request won arbitration |
| req_irq_o | output | 7 | Winning IRQ number |
| req_fast_o | output | 1 | Winner came from a fast channel |
| req_vec_o | output | 21 | Vector address to fetch |

## Verification
The bench goes after the ordering corners. It checks a matched IRQ that sits above a lower-indexed level-2 request, both channels hitting at once, and both match registers naming one IRQ. It also checks a matched IRQ at level 1 or 3 and a level-3 request alongside a fast hit. A design that ignored table position, preferred channel 1, or promoted at the wrong level would output the wrong IRQ or raise the fast flag. Using the wrong channel's vector would also show. Separate checks cover the reserved bits, which would read back as ones if stored, and disabled level-0 sources, which would wrongly win. The single-cycle latency is checked both before and after the clock edge.

// File: rtl/fast_irq_pkg.sv
package fast_irq_pkg;
  localparam int IRQ_W    = 7;
  localparam int LVL_W    = 2;
  localparam int DATA_W   = 16;
  localparam int ADDR_W   = 5;
  localparam int HI_W     = 5;
  localparam int VEC_W    = DATA_W + HI_W;
  localparam int N_FAST   = 2;
  localparam int REG_BASE = 11;  // channel 0 match offset
  localparam int REG_STEP = 3;   // match, low, high per channel
  localparam logic [LVL_W-1:0] FAST_LVL = 2'd2;
  localparam logic [LVL_W-1:0] TOP_LVL  = 2'd3;
endpackage

// File: rtl/fast_irq_regs.sv
module fast_irq_regs
  import fast_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [IRQ_W-1:0]  match_o [N_FAST],
  output logic [VEC_W-1:0]  vec_o   [N_FAST]
);
  logic [IRQ_W-1:0]  match_q [N_FAST];
  logic [DATA_W-1:0] lo_q    [N_FAST];
  logic [HI_W-1:0]   hi_q    [N_FAST];

  for (genvar c = 0; c < N_FAST; c++) begin : g_ch
    localparam logic [ADDR_W-1:0] A_M = ADDR_W'(REG_BASE + REG_STEP*c);
    localparam logic [ADDR_W-1:0] A_L = ADDR_W'(REG_BASE + REG_STEP*c + 1);
    localparam logic [ADDR_W-1:0] A_H = ADDR_W'(REG_BASE + REG_STEP*c + 2);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        match_q[c] <= '0;
        lo_q[c]    <= '0;
        hi_q[c]    <= '0;
      end else if (we_i) begin
        if (addr_i == A_M) match_q[c] <= wdata_i[IRQ_W-1:0];
        if (addr_i == A_L) lo_q[c]    <= wdata_i;
        if (addr_i == A_H) hi_q[c]    <= wdata_i[HI_W-1:0];
      end
    end

    assign match_o[c] = match_q[c];
    assign vec_o[c]   = {hi_q[c], lo_q[c]};

    AST_HI_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && addr_i == A_H) |=> vec_o[c][VEC_W-1:DATA_W] == $past(wdata_i[HI_W-1:0])); // R2
    AST_HI_RSVD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (addr_i == A_H) |-> rdata_o[DATA_W-1:HI_W] == '0); // R3
    AST_MATCH_RSVD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (addr_i == A_M) |-> rdata_o[DATA_W-1:IRQ_W] == '0); // R3
  end

  always_comb begin
    rdata_o = '0;
    for (int c = 0; c < N_FAST; c++) begin
      if (addr_i == ADDR_W'(REG_BASE + REG_STEP*c))     rdata_o = DATA_W'(match_q[c]);
      if (addr_i == ADDR_W'(REG_BASE + REG_STEP*c + 1)) rdata_o = lo_q[c];
      if (addr_i == ADDR_W'(REG_BASE + REG_STEP*c + 2)) rdata_o = DATA_W'(hi_q[c]);
    end
  end
endmodule

// File: rtl/fast_irq_fallback.sv
module fast_irq_fallback
  import fast_irq_pkg::*;
#(
  parameter int N_IRQ = 64
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_IRQ-1:0]       pend_i,
  input  logic [N_IRQ*LVL_W-1:0] lvl_i,
  output logic                   valid_o,
  output logic [LVL_W-1:0]       best_lvl_o,
  output logic [IRQ_W-1:0]       best_irq_o
);
  localparam int N_LVL = 1 << LVL_W;

  logic [N_LVL-1:0] lvl_any;
  logic [IRQ_W-1:0] lvl_idx [N_LVL];

  always_comb begin
    logic [LVL_W-1:0] lv;
    lvl_any = '0;
    for (int l = 0; l < N_LVL; l++) lvl_idx[l] = '0;
    // descending scan leaves the lowest index per level
    for (int k = N_IRQ-1; k >= 0; k--) begin
      lv = lvl_i[k*LVL_W +: LVL_W];
      if (pend_i[k] && lv != '0) begin
        lvl_any[lv] = 1'b1;
        lvl_idx[lv] = IRQ_W'(k);
      end
    end
    valid_o    = 1'b0;
    best_lvl_o = '0;
    best_irq_o = '0;
    for (int l = 1; l < N_LVL; l++) begin
      if (lvl_any[l]) begin
        valid_o    = 1'b1;
        best_lvl_o = LVL_W'(l);
        best_irq_o = lvl_idx[l];
      end
    end
  end

  AST_FB_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ((pend_i >> best_irq_o) & N_IRQ'(1)) != '0); // R4
  AST_FB_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_i == '0) |-> !valid_o); // R11
endmodule

// File: rtl/fast_irq_match.sv
module fast_irq_match
  import fast_irq_pkg::*;
#(
  parameter int N_IRQ = 64
) (
  input  logic [IRQ_W-1:0]       match_i,
  input  logic [N_IRQ-1:0]       pend_i,
  input  logic [N_IRQ*LVL_W-1:0] lvl_i,
  output logic                   hit_o
);
  always_comb begin
    hit_o = 1'b0;
    for (int k = 0; k < N_IRQ; k++) begin
      if (match_i == IRQ_W'(k))
        hit_o = pend_i[k] && (lvl_i[k*LVL_W +: LVL_W] == FAST_LVL);
    end
  end
endmodule

// File: rtl/fast_irq_override.sv
module fast_irq_override
  import fast_irq_pkg::*;
#(
  parameter int N_IRQ = 64
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [4:0]             reg_addr_i,
  input  logic                   reg_we_i,
  input  logic [15:0]            reg_wdata_i,
  output logic [15:0]            reg_rdata_o,
  input  logic [N_IRQ-1:0]       irq_pend_i,
  input  logic [2*N_IRQ-1:0]     irq_lvl_i,
  output logic                   req_valid_o,
  output logic [6:0]             req_irq_o,
  output logic                   req_fast_o,
  output logic [20:0]            req_vec_o
);
  logic [IRQ_W-1:0] match [N_FAST];
  logic [VEC_W-1:0] fvec  [N_FAST];
  logic [N_FAST-1:0] hit;
  logic             fb_valid;
  logic [LVL_W-1:0] fb_lvl;
  logic [IRQ_W-1:0] fb_irq;

  fast_irq_regs u_regs (
    .clk_i, .rst_ni,
    .addr_i(reg_addr_i), .we_i(reg_we_i), .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o), .match_o(match), .vec_o(fvec)
  );

  fast_irq_fallback #(.N_IRQ(N_IRQ)) u_fb (
    .clk_i, .rst_ni,
    .pend_i(irq_pend_i), .lvl_i(irq_lvl_i),
    .valid_o(fb_valid), .best_lvl_o(fb_lvl), .best_irq_o(fb_irq)
  );

  for (genvar c = 0; c < N_FAST; c++) begin : g_match
    fast_irq_match #(.N_IRQ(N_IRQ)) u_match (
      .match_i(match[c]), .pend_i(irq_pend_i), .lvl_i(irq_lvl_i), .hit_o(hit[c])
    );
  end

  logic             valid_d, fast_d;
  logic [IRQ_W-1:0] irq_d;
  logic [VEC_W-1:0] vec_d;

  always_comb begin
    valid_d = fb_valid;
    fast_d  = 1'b0;
    irq_d   = fb_irq;
    vec_d   = fb_valid ? VEC_W'({fb_irq, 1'b0}) : '0;
    // lowest channel wins; only when level 2 is the top active level
    for (int c = N_FAST-1; c >= 0; c--) begin
      if (fb_valid && fb_lvl == FAST_LVL && hit[c]) begin
        fast_d = 1'b1;
        irq_d  = match[c];
        vec_d  = fvec[c];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_valid_o <= 1'b0;
      req_fast_o  <= 1'b0;
      req_irq_o   <= '0;
      req_vec_o   <= '0;
    end else begin
      req_valid_o <= valid_d;
      req_fast_o  <= fast_d;
      req_irq_o   <= irq_d;
      req_vec_o   <= vec_d;
    end
  end

  AST_FAST0_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit[0] && fb_lvl == FAST_LVL) |=> req_fast_o && req_irq_o == $past(match[0])
                                       && req_vec_o == $past(fvec[0])); // R7
  AST_TOP_NO_FAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fb_valid && fb_lvl == TOP_LVL) |=> !req_fast_o); // R9
  AST_FAST_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_fast_o |-> req_valid_o); // R5
  AST_IDLE_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_pend_i == '0) |=> !req_valid_o && req_vec_o == '0 && !req_fast_o); // R11
endmodule

// File: tb/sim_fast_irq_override.sv
`timescale 1ns/1ps
module sim_fast_irq_override;
  localparam int N = 64;

  logic          clk = 0, rst_n = 0;
  logic [4:0]    addr = 0;
  logic          we = 0;
  logic [15:0]   wdata = 0;
  logic [15:0]   rdata;
  logic [N-1:0]  pend = 0;
  logic [2*N-1:0] lvl = 0;
  logic          vld, fst;
  logic [6:0]    irq;
  logic [20:0]   vec;

  int errors = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fast_irq_override #(.N_IRQ(N)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_addr_i(addr), .reg_we_i(we), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .irq_pend_i(pend), .irq_lvl_i(lvl),
    .req_valid_o(vld), .req_irq_o(irq), .req_fast_o(fst), .req_vec_o(vec)
  );

  typedef struct packed {
    logic [6:0] a; logic [1:0] la;
    logic [6:0] b; logic [1:0] lb;
    logic [6:0] c; logic [1:0] lc;
    logic ev; logic [6:0] ei; logic ef;
  } row_t;

  // channel 0 matches 20, channel 1 matches 5; 127 = unused slot
  localparam row_t TBL [12] = '{
    '{7'd10, 2'd1, 7'd127, 2'd0, 7'd127, 2'd0, 1'b1, 7'd10, 1'b0},  // R4
    '{7'd10, 2'd1, 7'd30,  2'd2, 7'd127, 2'd0, 1'b1, 7'd30, 1'b0},  // R4
    '{7'd3,  2'd2, 7'd20,  2'd2, 7'd127, 2'd0, 1'b1, 7'd20, 1'b1},  // R5
    '{7'd3,  2'd2, 7'd5,   2'd2, 7'd127, 2'd0, 1'b1, 7'd5,  1'b1},  // R5
    '{7'd5,  2'd2, 7'd20,  2'd2, 7'd127, 2'd0, 1'b1, 7'd20, 1'b1},  // R7
    '{7'd20, 2'd1, 7'd40,  2'd1, 7'd127, 2'd0, 1'b1, 7'd20, 1'b0},  // R6
    '{7'd20, 2'd3, 7'd2,   2'd2, 7'd127, 2'd0, 1'b1, 7'd20, 1'b0},  // R6
    '{7'd20, 2'd2, 7'd60,  2'd3, 7'd127, 2'd0, 1'b1, 7'd60, 1'b0},  // R9
    '{7'd20, 2'd0, 7'd7,   2'd1, 7'd127, 2'd0, 1'b1, 7'd7,  1'b0},  // R4
    '{7'd12, 2'd3, 7'd9,   2'd3, 7'd127, 2'd0, 1'b1, 7'd9,  1'b0},  // R4
    '{7'd127,2'd0, 7'd127, 2'd0, 7'd127, 2'd0, 1'b0, 7'd0,  1'b0},  // R11
    '{7'd5,  2'd1, 7'd20,  2'd1, 7'd1,   2'd2, 1'b1, 7'd1,  1'b0}   // R6
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input string tag, input logic [4:0] a, input logic [15:0] exp);
    @(negedge clk); addr = a; #1;
    chk(tag, 32'(rdata), 32'(exp));
  endtask

  task automatic put(input logic [6:0] n, input logic [1:0] l);
    if (n < N) begin pend[n] = 1; lvl[2*n +: 2] = l; end
  endtask

  task automatic outs(input string tag, input logic ev, input logic [6:0] ei,
                      input logic ef, input logic [20:0] evec);
    chk({tag, " valid"}, 32'(vld), 32'(ev));
    chk({tag, " irq"},   32'(irq), 32'(ei));
    chk({tag, " fast"},  32'(fst), 32'(ef));
    chk({tag, " vec"},   32'(vec), 32'(evec));
  endtask

  function automatic logic [20:0] exp_vec(input row_t r);
    if (!r.ev) return '0;
    if (r.ef) return (r.ei == 7'd20) ? 21'h151234 : 21'h0ABEEF;
    return 21'({r.ei, 1'b0});
  endfunction

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    outs("R1 reset", 0, 0, 0, 0);
    for (int a = 11; a <= 16; a++) rd("R1 reg", 5'(a), 16'h0);
    rst_n = 1;

    // R2 map and readback, R3 reserved bits
    wr(5'hB, 16'hFF94); rd("R3 match0 rsvd", 5'hB, 16'h0014);
    wr(5'hC, 16'h1234); rd("R2 lo0", 5'hC, 16'h1234);
    wr(5'hD, 16'hFFF5); rd("R3 hi0 rsvd", 5'hD, 16'h0015);
    wr(5'hE, 16'hFFFF); rd("R3 match1 rsvd", 5'hE, 16'h007F);
    wr(5'hE, 16'h0005); rd("R2 match1", 5'hE, 16'h0005);
    wr(5'hF, 16'hBEEF); rd("R2 lo1", 5'hF, 16'hBEEF);
    wr(5'h10, 16'h000A); rd("R2 hi1", 5'h10, 16'h000A);
    wr(5'h3, 16'hAAAA); rd("R2 unmapped", 5'h3, 16'h0000);
    rd("R2 unmapped 0x11", 5'h11, 16'h0000);

    // table walk
    foreach (TBL[i]) begin
      @(negedge clk);
      pend = '0; lvl = '0;
      put(TBL[i].a, TBL[i].la); put(TBL[i].b, TBL[i].lb); put(TBL[i].c, TBL[i].lc);
      @(negedge clk);
      outs($sformatf("R4/R5/R6/R7/R9/R11 row %0d", i), TBL[i].ev, TBL[i].ei,
           TBL[i].ef, exp_vec(TBL[i]));
    end

    // R10 latency: old value before edge, new after one edge
    @(negedge clk); pend = '0; lvl = '0; put(7'd33, 2'd1);
    @(negedge clk); outs("R10 settle", 1, 33, 0, 21'd66);
    pend = '0; lvl = '0; put(7'd20, 2'd2); #1;
    outs("R10 before edge", 1, 33, 0, 21'd66);
    @(negedge clk); outs("R10 after edge", 1, 20, 1, 21'h151234);

    // R8 same IRQ in both match registers
    wr(5'hE, 16'd20);
    @(negedge clk); outs("R8 same irq", 1, 20, 1, 21'h151234);

    // R5 fast channel above lower index at level 2, after match change
    wr(5'hB, 16'd40);
    @(negedge clk); pend = '0; lvl = '0; put(7'd0, 2'd2); put(7'd40, 2'd2);
    @(negedge clk); outs("R5 table position", 1, 40, 1, 21'h151234);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule